// File: doc/BRIEF.md
# Wide-Pattern Peripheral Clock Generator

This block produces the clock for an external peripheral as a data word rather than as a real clock. Every register in the block, and every register that uses its outputs, runs on the one source clock. On each source cycle the block emits a word of 1, 2 or 8 bits. A serializer, a two-bit double-data-rate output cell or a plain output flop then shifts that word onto the pin. Bit W-1 of the word leaves the pin first. The generated clock never clocks any logic.

Two strobes travel with the word. `cyc_start` marks the source cycle in which a device-clock period begins. `half_start` marks the cycle in which its second half begins. Transmit logic in the source domain uses these strobes to decide when to change data: on `cyc_start` for single-rate data, and also on `half_start` for double-rate data. Requests for a new divider, for a quarter-period (90 degree) offset, and for pausing are taken up only at a period boundary, so the pin never shows a shortened pulse. The settings in force are reported back on `act_div` and `act_shift`, so a driver can tell when a request has taken effect.

Top module: `wclk_gen`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `clk_word` is zero, both strobes are low, `act_div` is all ones (the slowest setting) and `act_shift` is 0.
- R2: The word width is 8 for `OUT_MODE` = OM_SER8, 2 for OM_DDR2 and 1 for OM_BIT. Bit W-1 is the earliest in time. With no offset, the pin is low for the first half of each device period and high for the second half. With offset, it is high from one quarter to three quarters of the period.
- R3: A divider of 0 fits two device periods in one source cycle. A divider of 1 fits exactly one device period in one source cycle. A divider D of 2 or more gives a half-period of D-1 source cycles, so a period of 2(D-1) cycles.
- R4: In OM_SER8 mode the word is 8'b00110011 for divider 0 without offset and 8'b01100110 with offset. For divider 1 it is 8'b00001111 without offset and 8'b00111100 with offset.
- R5: A divider request below the smallest legal value for the mode is raised to that value. The smallest legal value is 0 for OM_SER8, 1 for OM_DDR2 and 2 for OM_BIT.
- R6: An offset request is honoured only when a half-period spans at least two bit times. When it is not honoured, `act_shift` reads 0 and the word has no offset.
- R7: `cyc_start` is high exactly in the first source cycle of each period. For dividers of 2 or more, `half_start` is high exactly D-1 cycles after `cyc_start`.
- R8: For dividers 0 and 1, while running, both strobes are high in every cycle. For larger dividers the strobes are never high together.
- R9: Divider and offset requests are sampled only at a period boundary or while stopped. `act_div` and `act_shift` show the new values starting in the first cycle of the new period.
- R10: When `run_en` goes low mid-period, the current period completes. From the next cycle on, the word is zero and both strobes stay low.
- R11: When `run_en` is high while stopped, the next cycle begins a new period at its start, with `cyc_start` high.
- R12: Inputs are sampled on the rising edge. While the block is stopped, a new request appears on `act_div` and `act_shift` in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Clock enable; low pauses the device clock at the next period boundary |
| req_div | input | DIV_W | Requested divider setting |
| req_shift | input | 1 | Requested quarter-period offset |
| clk_word | output | W | Clock pattern for the output stage, MSB first |
| cyc_start | output | 1 | Strobe for the first cycle of a device period |
| half_start | output | 1 | Strobe for the cycle in which the second half begins |
| act_div | output | DIV_W | Divider in effect |
| act_shift | output | 1 | Offset in effect |

## Verification
The properties assume that `rst` is high from time zero and that every input is synchronous to `clk`. Apart from that, requests may change on any cycle and take any value, because values below the mode's minimum are raised rather than forbidden. The stimulus drives all inputs on the falling edge. It holds reset for several cycles before releasing it. It then feeds the three mode instances identical request streams, mostly at small dividers so that many boundaries, pauses and mid-period request changes occur, with the occasional large divider.

// File: rtl/wclk_pkg.sv
package wclk_pkg;

  typedef enum logic [1:0] {
    OM_BIT  = 2'd0,
    OM_DDR2 = 2'd1,
    OM_SER8 = 2'd2
  } outmode_e;

  // bits the output stage consumes per source cycle
  function automatic int word_bits(outmode_e m);
    case (m)
      OM_SER8: return 8;
      OM_DDR2: return 2;
      default: return 1;
    endcase
  endfunction

  // smallest divider the mode can express
  function automatic int min_div(outmode_e m);
    case (m)
      OM_SER8: return 0;
      OM_DDR2: return 1;
      default: return 2;
    endcase
  endfunction

endpackage

// File: rtl/wclk_rate_ctl.sv
// Period sequencing: position counter, boundary detection and the
// settings latched at each boundary. Exposes both present and next state.
module wclk_rate_ctl #(
  parameter int W       = 8,
  parameter int MIN_DIV = 0,
  parameter int DIV_W   = 8,
  parameter int CNT_W   = DIV_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_en,
  input  logic [DIV_W-1:0] req_div,
  input  logic             req_shift,
  output logic             run_n,
  output logic [CNT_W-1:0] cnt_n,
  output logic [DIV_W-1:0] div_n,
  output logic             sh_n,
  output logic [DIV_W-1:0] div_q,
  output logic             sh_q
);

  logic             run_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_cnt;
  logic             at_bound;
  logic [DIV_W-1:0] req_c;
  logic             sh_ok;

  // raise requests below the mode's minimum
  generate
    if (MIN_DIV == 0) begin : g_noclamp
      assign req_c = req_div;
    end else begin : g_clamp
      assign req_c = (req_div < DIV_W'(MIN_DIV)) ? DIV_W'(MIN_DIV) : req_div;
    end
  endgenerate

  // quarter period resolvable only if half-period spans two bit times
  generate
    if (W >= 8) begin : g_shall
      assign sh_ok = 1'b1;
    end else begin : g_shsome
      assign sh_ok = (req_c > DIV_W'(MIN_DIV));
    end
  endgenerate

  always_comb begin
    if (div_q <= DIV_W'(1)) begin
      last_cnt = '0;
    end else begin
      last_cnt = ({1'b0, div_q} << 1) - CNT_W'(3);
    end
  end

  assign at_bound = !run_q || (cnt_q == last_cnt);

  always_comb begin
    if (at_bound) begin
      run_n = run_en;
      cnt_n = '0;
      div_n = req_c;
      sh_n  = req_shift & sh_ok;
    end else begin
      run_n = 1'b1;
      cnt_n = cnt_q + CNT_W'(1);
      div_n = div_q;
      sh_n  = sh_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      div_q <= '1;
      sh_q  <= 1'b0;
    end else begin
      run_q <= run_n;
      cnt_q <= cnt_n;
      div_q <= div_n;
      sh_q  <= sh_n;
    end
  end

endmodule

// File: rtl/wclk_pattern.sv
// Combinational word and strobe generation for a given period position.
module wclk_pattern #(
  parameter int W     = 8,
  parameter int DIV_W = 8,
  parameter int CNT_W = DIV_W + 1
) (
  input  logic             run,
  input  logic [CNT_W-1:0] cnt,
  input  logic [DIV_W-1:0] div,
  input  logic             sh,
  output logic [W-1:0]     word,
  output logic             cstart,
  output logic             hstart
);

  localparam int LW    = $clog2(W);
  localparam int BW    = CNT_W + 4;
  localparam int HALFW = (W >= 2) ? W / 2 : 1;

  logic [BW-1:0] hb;
  logic [BW-1:0] qtr;
  logic [BW-1:0] hi_end;

  // half-period in bit times
  always_comb begin
    if (div == '0) begin
      hb = BW'(W / 4);
    end else if (div == DIV_W'(1)) begin
      hb = BW'(W / 2);
    end else begin
      hb = BW'(div - DIV_W'(1)) << LW;
    end
  end

  assign qtr    = hb >> 1;
  assign hi_end = qtr + hb;

  generate
    for (genvar j = 0; j < W; j++) begin : g_bit
      logic [BW-1:0] bpos;
      logic          bval;
      always_comb begin
        if (div == '0) begin
          bpos = BW'(j % HALFW);
        end else begin
          bpos = (BW'(cnt) << LW) + BW'(j);
        end
        if (sh) begin
          bval = (bpos >= qtr) && (bpos < hi_end);
        end else begin
          bval = (bpos >= hb);
        end
      end
      assign word[W-1-j] = run & bval;
    end
  endgenerate

  assign cstart = run && (cnt == '0);
  assign hstart = run && ((div <= DIV_W'(1)) ||
                          (cnt == CNT_W'(div) - CNT_W'(1)));

endmodule

// File: rtl/wclk_gen.sv
module wclk_gen
  import wclk_pkg::*;
#(
  parameter outmode_e OUT_MODE = OM_SER8,
  parameter int       DIV_W    = 8,
  localparam int      W        = word_bits(OUT_MODE)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_en,
  input  logic [DIV_W-1:0] req_div,
  input  logic             req_shift,
  output logic [W-1:0]     clk_word,
  output logic             cyc_start,
  output logic             half_start,
  output logic [DIV_W-1:0] act_div,
  output logic             act_shift
);

  localparam int MIN_DIV = min_div(OUT_MODE);
  localparam int CNT_W   = DIV_W + 1;

  logic             run_n;
  logic [CNT_W-1:0] cnt_n;
  logic [DIV_W-1:0] div_n;
  logic             sh_n;
  logic [DIV_W-1:0] div_q;
  logic             sh_q;
  logic [W-1:0]     word_n;
  logic             cs_n;
  logic             hs_n;

  wclk_rate_ctl #(
    .W      (W),
    .MIN_DIV(MIN_DIV),
    .DIV_W  (DIV_W),
    .CNT_W  (CNT_W)
  ) u_ctl (
    .clk      (clk),
    .rst      (rst),
    .run_en   (run_en),
    .req_div  (req_div),
    .req_shift(req_shift),
    .run_n    (run_n),
    .cnt_n    (cnt_n),
    .div_n    (div_n),
    .sh_n     (sh_n),
    .div_q    (div_q),
    .sh_q     (sh_q)
  );

  // pattern evaluated on next state so the output flops line up with it
  wclk_pattern #(
    .W    (W),
    .DIV_W(DIV_W),
    .CNT_W(CNT_W)
  ) u_pat (
    .run   (run_n),
    .cnt   (cnt_n),
    .div   (div_n),
    .sh    (sh_n),
    .word  (word_n),
    .cstart(cs_n),
    .hstart(hs_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_word   <= '0;
      cyc_start  <= 1'b0;
      half_start <= 1'b0;
    end else begin
      clk_word   <= word_n;
      cyc_start  <= cs_n;
      half_start <= hs_n;
    end
  end

  assign act_div   = div_q;
  assign act_shift = sh_q;

endmodule

// File: rtl/wclk_gen_chk.sv
module wclk_gen_chk
  import wclk_pkg::*;
#(
  parameter outmode_e OUT_MODE = OM_SER8,
  parameter int       DIV_W    = 8,
  localparam int      W        = word_bits(OUT_MODE),
  localparam int      MIN_DIV  = min_div(OUT_MODE)
) (
  input logic             clk,
  input logic             rst,
  input logic [W-1:0]     clk_word,
  input logic             cyc_start,
  input logic             half_start,
  input logic [DIV_W-1:0] act_div,
  input logic             act_shift
);

  // cycles since the last period start, saturating
  logic [DIV_W+1:0] since_cs;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_cs <= '0;
    end else if (cyc_start) begin
      since_cs <= (DIV_W+2)'(1);
    end else if (since_cs != '1) begin
      since_cs <= since_cs + (DIV_W+2)'(1);
    end
  end

  generate
    if (MIN_DIV > 0) begin : g_min
      p_min_div_r5: assert property (@(posedge clk) disable iff (rst)
        act_div >= DIV_W'(MIN_DIV));
    end
    if (W < 8) begin : g_sh
      p_shift_legal_r6: assert property (@(posedge clk) disable iff (rst)
        act_shift |-> (act_div > DIV_W'(MIN_DIV)));
    end
  endgenerate

  p_half_gap_r7: assert property (@(posedge clk) disable iff (rst)
    (half_start && act_div >= DIV_W'(2)) |->
      (since_cs == {2'b00, act_div} - (DIV_W+2)'(1)));

  p_pair_fast_r8: assert property (@(posedge clk) disable iff (rst)
    (cyc_start && half_start) |-> (act_div <= DIV_W'(1)));

  p_fast_both_r8: assert property (@(posedge clk) disable iff (rst)
    (act_div <= DIV_W'(1) && (cyc_start || half_start)) |->
      (cyc_start && half_start));

  p_slow_gap_r3: assert property (@(posedge clk) disable iff (rst)
    (cyc_start && act_div >= DIV_W'(2)) |=> !cyc_start);

  p_change_at_edge_r9: assert property (@(posedge clk) disable iff (rst)
    (act_div != $past(act_div) || act_shift != $past(act_shift)) |->
      (cyc_start || (clk_word == '0 && !half_start)));

endmodule

bind wclk_gen wclk_gen_chk #(
  .OUT_MODE(OUT_MODE),
  .DIV_W   (DIV_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .clk_word  (clk_word),
  .cyc_start (cyc_start),
  .half_start(half_start),
  .act_div   (act_div),
  .act_shift (act_shift)
);

// File: tb/sim_wclk_gen.sv
`timescale 1ns/1ps
module sim_wclk_gen;
  import wclk_pkg::*;

  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          run_en = 1'b0;
  logic          req_shift = 1'b0;
  logic [DW-1:0] req_div = '0;

  logic [7:0]    w0;
  logic [1:0]    w1;
  logic [0:0]    w2;
  logic [2:0]    cs, hs, ash;
  logic [DW-1:0] ad0, ad1, ad2;

  always #4 clk = ~clk;

  wclk_gen #(.OUT_MODE(OM_SER8), .DIV_W(DW)) u0 (
    .clk(clk), .rst(rst), .run_en(run_en), .req_div(req_div), .req_shift(req_shift),
    .clk_word(w0), .cyc_start(cs[0]), .half_start(hs[0]), .act_div(ad0), .act_shift(ash[0]));
  wclk_gen #(.OUT_MODE(OM_DDR2), .DIV_W(DW)) u1 (
    .clk(clk), .rst(rst), .run_en(run_en), .req_div(req_div), .req_shift(req_shift),
    .clk_word(w1), .cyc_start(cs[1]), .half_start(hs[1]), .act_div(ad1), .act_shift(ash[1]));
  wclk_gen #(.OUT_MODE(OM_BIT), .DIV_W(DW)) u2 (
    .clk(clk), .rst(rst), .run_en(run_en), .req_div(req_div), .req_shift(req_shift),
    .clk_word(w2), .cyc_start(cs[2]), .half_start(hs[2]), .act_div(ad2), .act_shift(ash[2]));

  int n_chk  = 0;
  int n_fail = 0;

  // reference state per instance (0: 8-bit, 1: 2-bit, 2: 1-bit)
  bit m_run [3];
  int m_cnt [3];
  int m_div [3];
  bit m_sh  [3];

  function automatic int wbits(int i);
    return (i == 0) ? 8 : (i == 1) ? 2 : 1;
  endfunction

  function automatic int lowest(int i);
    return (i == 0) ? 0 : (i == 1) ? 1 : 2;
  endfunction

  function automatic int period_len(int d);
    return (d <= 1) ? 1 : 2 * (d - 1);
  endfunction

  function automatic int half_bits(int i, int d);
    int w = wbits(i);
    if (d == 0) return w / 4;
    if (d == 1) return w / 2;
    return (d - 1) * w;
  endfunction

  // expected word from the waveform definition, bit W-1 first in time
  function automatic logic [7:0] exp_word(int i, int d, bit s, int c);
    logic [7:0] r = '0;
    int w  = wbits(i);
    int hb = half_bits(i, d);
    int pb = 2 * hb;
    for (int j = 0; j < w; j++) begin
      int b = (c * w + j) % pb;
      bit v = s ? ((b >= hb / 2) && (b < hb / 2 + hb)) : (b >= hb);
      r[w-1-j] = v;
    end
    return r;
  endfunction

  function automatic logic [7:0] get_word(int i);
    if (i == 0) return w0;
    if (i == 1) return {6'b0, w1};
    return {7'b0, w2};
  endfunction

  function automatic int get_div(int i);
    if (i == 0) return int'(ad0);
    if (i == 1) return int'(ad1);
    return int'(ad2);
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_step();
    for (int i = 0; i < 3; i++) begin
      if (rst) begin
        m_run[i] = 1'b0; m_cnt[i] = 0; m_div[i] = (1 << DW) - 1; m_sh[i] = 1'b0;
      end else if (!m_run[i] || m_cnt[i] == period_len(m_div[i]) - 1) begin
        int d = int'(req_div);
        if (d < lowest(i)) d = lowest(i);
        m_run[i] = run_en;
        m_div[i] = d;
        m_sh[i]  = req_shift && (half_bits(i, d) >= 2);
        m_cnt[i] = 0;
      end else begin
        m_cnt[i]++;
      end
    end
  endtask

  task automatic compare_all();
    for (int i = 0; i < 3; i++) begin
      logic [7:0] ew = m_run[i] ? exp_word(i, m_div[i], m_sh[i], m_cnt[i]) : 8'h00;
      bit ec = m_run[i] && (m_cnt[i] == 0);
      bit eh = m_run[i] && (m_div[i] <= 1 || m_cnt[i] == m_div[i] - 1);
      check("R2", $sformatf("u%0d word", i), int'(get_word(i)), int'(ew));
      check("R7", $sformatf("u%0d cyc_start", i), int'(cs[i]), int'(ec));
      check("R7", $sformatf("u%0d half_start", i), int'(hs[i]), int'(eh));
      check("R9", $sformatf("u%0d act_div", i), get_div(i), m_div[i]);
      check("R9", $sformatf("u%0d act_shift", i), int'(ash[i]), int'(m_sh[i]));
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R12 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20251));
    // reset phase
    repeat (4) step();
    check("R1", "u0 act_div", int'(ad0), 255);
    check("R1", "u0 word", int'(w0), 0);
    check("R1", "u2 act_shift", int'(ash[2]), 0);
    rst = 1'b0;
    step();
    check("R1", "u0 word after release", int'(w0), 0);

    // fastest setting, no offset then offset
    run_en = 1'b1; req_div = 0; req_shift = 1'b0;
    step();
    check("R4", "u0 div0 word", int'(w0), 8'h33);
    check("R8", "u0 both strobes", int'(cs[0] & hs[0]), 1);
    check("R5", "u1 clamp", int'(ad1), 1);
    check("R5", "u2 clamp", int'(ad2), 2);
    check("R3", "u1 one period per word", int'(w1), 2'b01);
    req_shift = 1'b1;
    step();
    check("R4", "u0 div0 offset word", int'(w0), 8'h66);
    check("R6", "u0 offset honoured", int'(ash[0]), 1);
    check("R6", "u1 offset refused", int'(ash[1]), 0);
    req_div = 1;
    step();
    check("R4", "u0 div1 offset word", int'(w0), 8'h3C);
    req_shift = 1'b0;
    step();
    check("R4", "u0 div1 word", int'(w0), 8'h0F);

    // divider 3: period of 4 cycles, half after 2
    req_div = 3;
    step();
    check("R3", "u0 period start", int'(cs[0]), 1);
    for (int k = 1; k <= 4; k++) begin
      step();
      check("R7", "u0 half position", int'(hs[0]), int'(k == 2));
      check("R3", "u0 period length", int'(cs[0]), int'(k == 4));
      check("R8", "u0 strobes apart", int'(cs[0] & hs[0]), 0);
      check("R2", "u0 slow word", int'(w0), ((k % 4) >= 2) ? 8'hFF : 8'h00);
    end

    // request mid-period waits for the boundary
    req_div = 5; req_shift = 1'b1;
    step();
    check("R9", "u0 act_div held", int'(ad0), 3);
    check("R9", "u0 act_shift held", int'(ash[0]), 0);
    step(); step(); step();
    check("R9", "u0 act_div applied", int'(ad0), 5);
    check("R9", "u0 act_shift applied", int'(ash[0]), 1);
    check("R9", "u0 new period", int'(cs[0]), 1);

    // pause mid-period: period completes, then silence
    run_en = 1'b0;
    step(); step();
    check("R10", "u0 still running", int'(w0), 8'hFF);
    repeat (5) step();
    check("R10", "u0 last cycle", int'(w0), 8'h00);
    step();
    check("R10", "u0 stopped word", int'(w0), 0);
    check("R10", "u0 stopped strobes", int'(cs[0] | hs[0]), 0);
    repeat (10) step();
    check("R10", "u1 stopped", int'(w1), 0);
    check("R10", "u2 stopped", int'(w2), 0);

    // while stopped, requests show next cycle
    req_div = 4; req_shift = 1'b0;
    step();
    check("R12", "u0 act_div while stopped", int'(ad0), 4);
    req_div = 2; req_shift = 1'b1;
    step();
    check("R6", "u2 offset refused at div2", int'(ash[2]), 0);
    check("R6", "u1 offset at div2", int'(ash[1]), 1);
    req_div = 3;
    step();
    check("R6", "u2 offset at div3", int'(ash[2]), 1);
    req_div = 0;
    step();
    check("R5", "u2 clamp while stopped", int'(ad2), 2);

    // resume
    req_div = 4; req_shift = 1'b0; run_en = 1'b1;
    step();
    check("R11", "u0 restart", int'(cs[0]), 1);
    check("R11", "u2 restart", int'(cs[2]), 1);
    check("R11", "u0 restart word", int'(w0), 0);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      if (($urandom % 12) == 0) begin
        run_en    = (($urandom % 6) != 0);
        req_div   = (($urandom % 20) == 0) ? DW'($urandom % 40) : DW'($urandom % 7);
        req_shift = $urandom % 2;
      end
      step();
    end

    summary();
    $finish;
  end

endmodule